// File: doc/BRIEF.md
# Host Bus Slave with Ratio-Keyed Acknowledge Delay

This block is a synchronous slave on a 68000-style asynchronous-protocol host bus whose signals are sampled on the bus clock. The host opens a cycle by pulling chip select low together with one or both byte write strobes, or with the read enable. The slave latches the 17-bit address on that first edge. It then holds the acknowledge line driven high while a wait count runs, and pulls acknowledge low when the count ends. The length of the count depends on the divide ratio between the internal memory clock and the bus clock.

Writes go into a byte-laned write buffer. The buffer takes the data on the third bus clock of the cycle and commits it on the edge that asserts acknowledge. Reads fetch a word from a simple internal read port on the acknowledge edge and drive it onto the data bus. The data bus and the acknowledge line are open lines, so each is presented as a value plus a drive enable for the pad ring.

A single state machine sequences every cycle. ST_BLOCK waits for chip select to be seen high and moves to ST_IDLE when it is. ST_IDLE moves to ST_WAIT when chip select is low with a strobe. ST_WAIT moves to ST_ACK when the count ends, or to ST_HOLD if chip select rises first (an abort). ST_ACK moves to ST_HOLD when chip select rises. ST_HOLD always moves to ST_IDLE on the next edge. Reset enters ST_BLOCK.

Top module: `hostbus_slave`

## Requirements
- R1: During and right after reset, the acknowledge enable, data bus enable and commit pulse are 0, and the write buffer data, address and lane enables are all 0.
- R2: The acknowledge value goes low exactly N edges after the start edge, counting the start edge as edge 1. N is chosen by `clk_ratio` as latched at the start edge: 00 gives 8, 01 gives 13, 10 gives 16 and 11 gives 22.
- R3: Write data is taken from `bus_din` on edge 3 of the cycle. A change of `bus_din` after edge 3 does not reach the buffer.
- R4: On commit, `wb_data[15:8]` is updated only if `bus_wr_hi_n` was low on edge 3, and `wb_data[7:0]` only if `bus_wr_lo_n` was low. `wb_lane_en` is {hi, lo} active high. `wb_commit` is a one-cycle pulse in the first cycle that acknowledge is low.
- R5: In a read cycle, `bus_dout` holds the read port word for the latched address from the cycle in which acknowledge goes low. `bus_dout_en` is 1 only in ST_WAIT or ST_ACK of a read cycle while chip select and read enable are both low.
- R6: Acknowledge is driven (`ack_n_en`=1) with value 1 from the edge after the start edge until the count ends. It is never 0 while undriven.
- R7: After chip select is sampled high in ST_ACK, acknowledge is driven high for one cycle and then released (`ack_n_en`=0).
- R8: If chip select rises before the count ends, the cycle aborts. Acknowledge never goes low, there is no commit pulse, and the write buffer keeps its value.
- R9: After reset, no cycle starts until chip select has been sampled high on at least one edge.
- R10: `rd_addr` and `wb_addr` carry the address sampled on the start edge. Later changes of `bus_addr` are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_ratio | input | 2 | Memory-to-bus clock divide ratio selector |
| bus_cs_n | input | 1 | Chip select, active low |
| bus_wr_hi_n | input | 1 | Upper byte write strobe, active low |
| bus_wr_lo_n | input | 1 | Lower byte write strobe, active low |
| bus_rd_n | input | 1 | Read (output) enable, active low |
| bus_addr | input | 17 | Host address |
| bus_din | input | 16 | Write data from host |
| bus_dout | output | 16 | Read data toward host |
| bus_dout_en | output | 1 | Drive enable for the data bus |
| ack_n_val | output | 1 | Acknowledge level, active low |
| ack_n_en | output | 1 | Drive enable for the acknowledge line |
| rd_addr | output | 17 | Read port address (latched) |
| rd_data | input | 16 | Read port data |
| wb_commit | output | 1 | Write buffer commit pulse |
| wb_addr | output | 17 | Write buffer address |
| wb_data | output | 16 | Write buffer data |
| wb_lane_en | output | 2 | Byte lanes written by the last commit |

## Verification
The assertions check several rules on every cycle. The acknowledge fall must match the latched ratio's latency, and acknowledge may never be low while undriven. The data bus may be driven only with chip select and read enable low. A commit may only occur on the acknowledge edge, and buffer data may change only on a commit. After the cycle ends, acknowledge must be driven high for one cycle and then released. Other behaviours can only be shown by the bench's scenarios: the third-edge capture of write data, per-lane merging, read data values, abort without side effects, address latching, and the refusal to start before chip select has been seen high.

// File: rtl/hostbus_pkg.sv
package hostbus_pkg;

    typedef enum logic [2:0] {
        ST_BLOCK,
        ST_IDLE,
        ST_WAIT,
        ST_ACK,
        ST_HOLD
    } hb_state_e;

endpackage

// File: rtl/hostbus_ctrl.sv
module hostbus_ctrl
    import hostbus_pkg::*;
#(
    parameter int LAT_DIV1 = 8,
    parameter int LAT_DIV2 = 13,
    parameter int LAT_DIV3 = 16,
    parameter int LAT_DIV4 = 22,
    parameter int CNT_W    = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       ratio,
    input  logic             cs_n,
    input  logic             wr_hi_n,
    input  logic             wr_lo_n,
    input  logic             rd_n,
    output hb_state_e        state_o,
    output logic             start_o,
    output logic             cap_o,
    output logic             fire_o,
    output logic             is_wr_o,
    output logic [CNT_W-1:0] lat_o,
    output logic             ack_val_o,
    output logic             ack_en_o
);

    hb_state_e        state_q, state_d;
    logic [CNT_W-1:0] lat_sel, lat_q, cnt_q;
    logic             is_wr_q, req;

    always_comb begin
        unique case (ratio)
            2'd0: lat_sel = CNT_W'(LAT_DIV1);
            2'd1: lat_sel = CNT_W'(LAT_DIV2);
            2'd2: lat_sel = CNT_W'(LAT_DIV3);
            2'd3: lat_sel = CNT_W'(LAT_DIV4);
        endcase
    end

    assign req = !cs_n && (!wr_hi_n || !wr_lo_n || !rd_n);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_BLOCK: if (cs_n) state_d = ST_IDLE;
            ST_IDLE:  if (req) state_d = ST_WAIT;
            ST_WAIT: begin
                if (cs_n) state_d = ST_HOLD;
                else if (cnt_q == '0) state_d = ST_ACK;
            end
            ST_ACK:   if (cs_n) state_d = ST_HOLD;
            ST_HOLD:  state_d = ST_IDLE;
            default:  state_d = ST_BLOCK;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_BLOCK;
        else        state_q <= state_d;
    end

    // wait counter and per-cycle latches
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            lat_q   <= '0;
            is_wr_q <= 1'b0;
        end else if (start_o) begin
            cnt_q   <= lat_sel - CNT_W'(2);
            lat_q   <= lat_sel;
            is_wr_q <= !wr_hi_n || !wr_lo_n;
        end else if (state_q == ST_WAIT && cnt_q != '0) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end else if (state_q == ST_HOLD) begin
            cnt_q <= '0;
        end
    end

    // outputs
    always_comb begin
        start_o   = (state_q == ST_IDLE) && req;
        fire_o    = (state_q == ST_WAIT) && !cs_n && (cnt_q == '0);
        cap_o     = (state_q == ST_WAIT) && !cs_n && (cnt_q == lat_q - CNT_W'(3));
        ack_en_o  = (state_q == ST_WAIT) || (state_q == ST_ACK) || (state_q == ST_HOLD);
        ack_val_o = (state_q != ST_ACK);
        state_o   = state_q;
        is_wr_o   = is_wr_q;
        lat_o     = lat_q;
    end

endmodule

// File: rtl/hostbus_wbuf.sv
module hostbus_wbuf #(
    parameter int ADDR_W = 17,
    parameter int DATA_W = 16,
    parameter int LANES  = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap,
    input  logic              fire,
    input  logic              is_wr,
    input  logic [DATA_W-1:0] din,
    input  logic [LANES-1:0]  lane_n,
    input  logic [ADDR_W-1:0] addr_lat,
    output logic [ADDR_W-1:0] wb_addr,
    output logic [DATA_W-1:0] wb_data,
    output logic [LANES-1:0]  wb_be,
    output logic              wb_commit
);

    logic [DATA_W-1:0] stage_data;
    logic [LANES-1:0]  stage_be;
    logic              commit_now;

    assign commit_now = fire && is_wr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_data <= '0;
            stage_be   <= '0;
        end else if (cap) begin
            stage_data <= din;
            stage_be   <= ~lane_n;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wb_addr   <= '0;
            wb_be     <= '0;
            wb_commit <= 1'b0;
        end else begin
            wb_commit <= commit_now;
            if (commit_now) begin
                wb_addr <= addr_lat;
                wb_be   <= stage_be;
            end
        end
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                wb_data[g*8 +: 8] <= '0;
            else if (commit_now && stage_be[g])
                wb_data[g*8 +: 8] <= stage_data[g*8 +: 8];
        end
    end

endmodule

// File: rtl/hostbus_rdpath.sv
module hostbus_rdpath
    import hostbus_pkg::*;
#(
    parameter int ADDR_W = 17,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  hb_state_e         state,
    input  logic              start,
    input  logic              fire,
    input  logic              is_wr,
    input  logic              cs_n,
    input  logic              rd_n,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] dout,
    output logic              dout_en
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            dout   <= '0;
        end else begin
            if (start) addr_q <= addr_in;
            if (fire && !is_wr) dout <= rd_data;
        end
    end

    assign dout_en = !is_wr && (state == ST_WAIT || state == ST_ACK) && !cs_n && !rd_n;

endmodule

// File: rtl/hostbus_slave.sv
module hostbus_slave
    import hostbus_pkg::*;
#(
    parameter int ADDR_W   = 17,
    parameter int DATA_W   = 16,
    parameter int LAT_DIV1 = 8,
    parameter int LAT_DIV2 = 13,
    parameter int LAT_DIV3 = 16,
    parameter int LAT_DIV4 = 22
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [1:0]            clk_ratio,
    input  logic                  bus_cs_n,
    input  logic                  bus_wr_hi_n,
    input  logic                  bus_wr_lo_n,
    input  logic                  bus_rd_n,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [DATA_W-1:0]     bus_din,
    output logic [DATA_W-1:0]     bus_dout,
    output logic                  bus_dout_en,
    output logic                  ack_n_val,
    output logic                  ack_n_en,
    output logic [ADDR_W-1:0]     rd_addr,
    input  logic [DATA_W-1:0]     rd_data,
    output logic                  wb_commit,
    output logic [ADDR_W-1:0]     wb_addr,
    output logic [DATA_W-1:0]     wb_data,
    output logic [DATA_W/8-1:0]   wb_lane_en
);

    localparam int LANES   = DATA_W / 8;
    localparam int LAT_MAX = (LAT_DIV4 > LAT_DIV3) ? LAT_DIV4 : LAT_DIV3;
    localparam int CNT_W   = $clog2(LAT_MAX + 1);

    hb_state_e        state;
    logic             start, cap, fire, is_wr;
    logic [CNT_W-1:0] lat_cur;
    logic [LANES-1:0] lane_n;

    assign lane_n = {bus_wr_hi_n, bus_wr_lo_n};

    hostbus_ctrl #(
        .LAT_DIV1(LAT_DIV1), .LAT_DIV2(LAT_DIV2),
        .LAT_DIV3(LAT_DIV3), .LAT_DIV4(LAT_DIV4), .CNT_W(CNT_W)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .ratio(clk_ratio), .cs_n(bus_cs_n),
        .wr_hi_n(bus_wr_hi_n), .wr_lo_n(bus_wr_lo_n), .rd_n(bus_rd_n),
        .state_o(state), .start_o(start), .cap_o(cap), .fire_o(fire),
        .is_wr_o(is_wr), .lat_o(lat_cur), .ack_val_o(ack_n_val), .ack_en_o(ack_n_en)
    );

    hostbus_rdpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rd (
        .clk(clk), .rst_n(rst_n), .state(state), .start(start), .fire(fire),
        .is_wr(is_wr), .cs_n(bus_cs_n), .rd_n(bus_rd_n), .addr_in(bus_addr),
        .rd_data(rd_data), .addr_q(rd_addr), .dout(bus_dout), .dout_en(bus_dout_en)
    );

    hostbus_wbuf #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANES(LANES)) u_wb (
        .clk(clk), .rst_n(rst_n), .cap(cap), .fire(fire), .is_wr(is_wr),
        .din(bus_din), .lane_n(lane_n), .addr_lat(rd_addr),
        .wb_addr(wb_addr), .wb_data(wb_data), .wb_be(wb_lane_en), .wb_commit(wb_commit)
    );

endmodule

// File: rtl/hostbus_slave_chk.sv
module hostbus_slave_chk #(
    parameter int DATA_W = 16,
    parameter int CNT_W  = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_cs_n,
    input logic              bus_rd_n,
    input logic              bus_dout_en,
    input logic              ack_n_val,
    input logic              ack_n_en,
    input logic              wb_commit,
    input logic [DATA_W-1:0] wb_data,
    input logic [CNT_W-1:0]  lat_cur
);

    logic [7:0] wait_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          wait_cnt <= '0;
        else if (!ack_n_en)  wait_cnt <= '0;
        else if (ack_n_val)  wait_cnt <= wait_cnt + 8'd1;
    end

    assert_ack_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ack_n_val) |-> (wait_cnt == 8'(lat_cur) - 8'd1));

    assert_ack_driven_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_n_val |-> ack_n_en);

    assert_dbus_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
        bus_dout_en |-> (!bus_cs_n && !bus_rd_n));

    assert_commit_on_ack_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wb_commit |-> $fell(ack_n_val));

    assert_buf_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !wb_commit |-> $stable(wb_data));

    assert_end_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_n_en && !ack_n_val && bus_cs_n) |=> (ack_n_en && ack_n_val));

    assert_end_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_n_en && ack_n_val && $past(!ack_n_val)) |=> !ack_n_en);

endmodule

bind hostbus_slave hostbus_slave_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_cs_n(bus_cs_n), .bus_rd_n(bus_rd_n),
    .bus_dout_en(bus_dout_en), .ack_n_val(ack_n_val), .ack_n_en(ack_n_en),
    .wb_commit(wb_commit), .wb_data(wb_data), .lat_cur(lat_cur)
);

// File: tb/hostbus_slave_tb.sv
module hostbus_slave_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  clk_ratio = 2'd0;
    logic        bus_cs_n = 1'b1, bus_wr_hi_n = 1'b1, bus_wr_lo_n = 1'b1, bus_rd_n = 1'b1;
    logic [16:0] bus_addr = '0;
    logic [15:0] bus_din = '0;
    logic [15:0] bus_dout, rd_data, wb_data;
    logic        bus_dout_en, ack_n_val, ack_n_en, wb_commit;
    logic [16:0] rd_addr, wb_addr;
    logic [1:0]  wb_lane_en;

    int checks = 0;
    int fails  = 0;
    bit cmp_on = 0;
    logic [15:0] exp_buf = '0;

    always #10 clk = ~clk;

    function automatic logic [15:0] mem_word(input logic [16:0] a);
        return a[15:0] ^ 16'h5A3C ^ {15'd0, a[16]};
    endfunction

    function automatic int lat_of(input logic [1:0] r);
        case (r)
            2'd0: return 8;
            2'd1: return 13;
            2'd2: return 16;
            default: return 22;
        endcase
    endfunction

    assign rd_data = mem_word(rd_addr);

    hostbus_slave u_dut (
        .clk(clk), .rst_n(rst_n), .clk_ratio(clk_ratio), .bus_cs_n(bus_cs_n),
        .bus_wr_hi_n(bus_wr_hi_n), .bus_wr_lo_n(bus_wr_lo_n), .bus_rd_n(bus_rd_n),
        .bus_addr(bus_addr), .bus_din(bus_din), .bus_dout(bus_dout),
        .bus_dout_en(bus_dout_en), .ack_n_val(ack_n_val), .ack_n_en(ack_n_en),
        .rd_addr(rd_addr), .rd_data(rd_data), .wb_commit(wb_commit),
        .wb_addr(wb_addr), .wb_data(wb_data), .wb_lane_en(wb_lane_en)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference: phase 0 blocked, 1 idle, 2 counting, 3 acked, 4 hold
    int          m_ph = 0, m_k = 0, m_lat = 0;
    bit          m_wr = 0, m_commit = 0;
    logic [16:0] m_addr = '0, m_wbaddr = '0;
    logic [15:0] m_stage = '0, m_buf = '0, m_dout = '0;
    logic [1:0]  m_sbe = '0, m_be = '0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ph = 0; m_k = 0; m_commit = 0; m_buf = '0; m_wbaddr = '0;
            m_be = '0; m_dout = '0; m_addr = '0;
        end else begin
            m_commit = 0;
            case (m_ph)
                0: if (bus_cs_n) m_ph = 1;
                1: if (!bus_cs_n && (!bus_wr_hi_n || !bus_wr_lo_n || !bus_rd_n)) begin
                       m_ph = 2; m_k = 1; m_lat = lat_of(clk_ratio);
                       m_wr = !bus_wr_hi_n || !bus_wr_lo_n; m_addr = bus_addr;
                   end
                2: if (bus_cs_n) m_ph = 4;
                   else begin
                       m_k++;
                       if (m_k == 3) begin m_stage = bus_din; m_sbe = ~{bus_wr_hi_n, bus_wr_lo_n}; end
                       if (m_k == m_lat) begin
                           m_ph = 3;
                           if (m_wr) begin
                               m_commit = 1; m_wbaddr = m_addr; m_be = m_sbe;
                               if (m_sbe[1]) m_buf[15:8] = m_stage[15:8];
                               if (m_sbe[0]) m_buf[7:0]  = m_stage[7:0];
                           end else m_dout = mem_word(m_addr);
                       end
                   end
                3: if (bus_cs_n) m_ph = 4;
                default: m_ph = 1;
            endcase
        end
    end

    // per-cycle comparison against the reference
    always @(negedge clk) begin
        if (cmp_on && rst_n) begin
            chk(ack_n_en == (m_ph >= 2), "R6 ack_n_en", 32'(ack_n_en), 32'(m_ph >= 2));
            chk(ack_n_val == (m_ph != 3), "R2 ack_n_val", 32'(ack_n_val), 32'(m_ph != 3));
            chk(bus_dout_en == (!m_wr && (m_ph == 2 || m_ph == 3) && !bus_cs_n && !bus_rd_n),
                "R5 dout_en", 32'(bus_dout_en), 32'(!m_wr && (m_ph == 2 || m_ph == 3) && !bus_cs_n && !bus_rd_n));
            if (m_ph == 3 && !m_wr) chk(bus_dout == m_dout, "R5 dout", 32'(bus_dout), 32'(m_dout));
            chk(wb_commit == m_commit, "R8 commit", 32'(wb_commit), 32'(m_commit));
            chk(wb_data == m_buf, "R4 wb_data", 32'(wb_data), 32'(m_buf));
            chk(wb_lane_en == m_be, "R4 lanes", 32'(wb_lane_en), 32'(m_be));
            chk(wb_addr == m_wbaddr, "R10 wb_addr", 32'(wb_addr), 32'(m_wbaddr));
        end
    end

    task automatic run_cycle(input logic [1:0] ratio, input bit wr, input logic [1:0] lanes,
                             input logic [16:0] a, input logic [15:0] d, input int abort_at);
        int  lat_seen = 0;
        bit  saw_commit = 0;
        @(negedge clk); #2;
        clk_ratio = ratio; bus_addr = a; bus_din = d; bus_cs_n = 1'b0;
        if (wr) {bus_wr_hi_n, bus_wr_lo_n} = ~lanes; else bus_rd_n = 1'b0;
        for (int n = 1; n <= 40; n++) begin
            @(negedge clk); #1;
            if (wb_commit) saw_commit = 1;
            if (lat_seen == 0 && !ack_n_val) lat_seen = n;
            if (n == 1) bus_addr = ~a;        // R10: later address ignored
            if (n == 3) bus_din = ~d;         // R3: only edge-3 data counts
            if (lat_seen != 0 || n == abort_at) break;
        end
        if (abort_at != 0) begin
            chk(lat_seen == 0 && !saw_commit, "R8 abort", 32'(lat_seen), 32'd0);
        end else begin
            chk(lat_seen == lat_of(ratio), "R2 latency", 32'(lat_seen), 32'(lat_of(ratio)));
            if (wr) begin
                if (lanes[1]) exp_buf[15:8] = d[15:8];
                if (lanes[0]) exp_buf[7:0] = d[7:0];
                chk(saw_commit && wb_lane_en == lanes, "R4 commit lanes", 32'(wb_lane_en), 32'(lanes));
                chk(wb_data == exp_buf, "R3 wb_data", 32'(wb_data), 32'(exp_buf));
                chk(wb_addr == a, "R10 wb_addr", 32'(wb_addr), 32'(a));
            end else begin
                chk(bus_dout_en && bus_dout == mem_word(a), "R5 read", 32'(bus_dout), 32'(mem_word(a)));
                chk(rd_addr == a, "R10 rd_addr", 32'(rd_addr), 32'(a));
            end
        end
        bus_cs_n = 1'b1; bus_wr_hi_n = 1'b1; bus_wr_lo_n = 1'b1; bus_rd_n = 1'b1;
        @(negedge clk); #1;
        chk(ack_n_en && ack_n_val, "R7 drive high", 32'({ack_n_en, ack_n_val}), 32'b11);
        @(negedge clk); #1;
        chk(!ack_n_en && !bus_dout_en, "R7 release", 32'({ack_n_en, bus_dout_en}), 32'b00);
        chk(wb_data == exp_buf, "R8 buffer kept", 32'(wb_data), 32'(exp_buf));
    endtask

    initial begin
        repeat (30000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        // R9 setup: chip select and a strobe held low through reset
        bus_cs_n = 1'b0; bus_wr_lo_n = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        chk(!ack_n_en && !bus_dout_en && !wb_commit, "R1 reset outputs",
            32'({ack_n_en, bus_dout_en, wb_commit}), 32'd0);
        chk(wb_data == 16'd0 && wb_addr == 17'd0 && wb_lane_en == 2'd0, "R1 reset buffer",
            32'(wb_data), 32'd0);
        #1 rst_n = 1'b1;
        cmp_on = 1;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk); #1;
            chk(!ack_n_en, "R9 no start without cs high", 32'(ack_n_en), 32'd0);
        end
        bus_cs_n = 1'b1; bus_wr_lo_n = 1'b1;
        @(negedge clk);
        run_cycle(2'd0, 1'b1, 2'b11, 17'h10A55, 16'hBEEF, 0);
        run_cycle(2'd1, 1'b1, 2'b10, 17'h00123, 16'h1234, 0);
        run_cycle(2'd2, 1'b1, 2'b01, 17'h1FFFF, 16'h5678, 0);
        run_cycle(2'd3, 1'b0, 2'b00, 17'h0ABCD, 16'h0000, 0);
        run_cycle(2'd0, 1'b0, 2'b00, 17'h13579, 16'h0000, 0);
        run_cycle(2'd1, 1'b1, 2'b11, 17'h00777, 16'hDEAD, 5);
        run_cycle(2'd3, 1'b1, 2'b01, 17'h00888, 16'hCAFE, 20);
        run_cycle(2'd3, 1'b1, 2'b11, 17'h04242, 16'hA5A5, 0);
        run_cycle(2'd2, 1'b0, 2'b00, 17'h10000, 16'h0000, 0);
        repeat (3) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule